// File: doc/BRIEF.md
# Rotating-Priority Request Ordering Unit

This unit sits at one node of a many-core mesh. It makes coherence requests that reach the node out of order be consumed in one global order that every node agrees on. A side network delivers, once per ordering window, a bit vector with one bit per core that sent a request in that window. The unit queues these vectors. It works through them one window at a time and walks the set cores of the current window in a priority ranking that rotates by one core each window.

Request headers from the main network arrive tagged with their source core. They can come at any time and in any order, and each one waits in a per-core slot. A header leaves on the output valid/ready channel only when its source is the next core in the current window's ranking. The output also carries the source core and the window number. The local snoop logic consumes that stream and so sees every request in the same sequence as every other node.

Top module: `order_release_unit`

## Requirements
- R1: After reset, outValid is 0, notifyReady is 1 and reqReady is 1 for every source.
- R2: Accepted notification vectors are numbered 0, 1, 2, … in the order they are accepted. outWin carries the number of the window whose request is on the output and wraps at 2^WIN_W.
- R3: In window w the top-ranked core is w mod NUM_CORES, and rank falls with increasing core index modulo NUM_CORES. The cores set in that window's vector are released in this ranked order.
- R4: A held header is not output while any higher-ranked core notified in the same window is still unreleased. outValid is 1 exactly when the next ranked core's header is held.
- R5: Every notified core of a window is released before any request of a later window. Requests from one core must arrive in window order.
- R6: An all-zero notification vector produces no output but still uses up its window number.
- R7: Up to FIFO_DEPTH windows can be pending, counting the one being served. notifyReady is 0 while that many are pending.
- R8: Each core has one header slot. reqReady is 0 while the slot for reqSrc is occupied, and outHdr is the header stored for outSrc.
- R9: While outValid is 1 and outReady is 0, outValid stays 1 and outSrc, outHdr and outWin do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| notifyValid | input | 1 | Window vector offered |
| notifyVec | input | NUM_CORES | One bit per core that requested in the window |
| notifyReady | output | 1 | Window queue has room |
| reqValid | input | 1 | Request header offered |
| reqSrc | input | $clog2(NUM_CORES) | Source core of the header |
| reqHdr | input | HDR_W | Request header |
| reqReady | output | 1 | Slot for reqSrc is free |
| outValid | output | 1 | Ordered header available |
| outReady | input | 1 | Consumer takes the header |
| outSrc | output | $clog2(NUM_CORES) | Source core of the released header |
| outHdr | output | HDR_W | Released header |
| outWin | output | WIN_W | Window number of the released header |

## Verification
Assertions check on every cycle that pushes never reach a full queue and that accepts never overwrite an occupied slot. They also check that each release belongs to a notified, not yet released core of the head window, that every retire advances the window number and the rotation offset by one, and that a stalled output holds steady. Only the bench scenarios can show the end-to-end order. These cover early arrivals from low-ranked cores, empty windows, a full window queue, offsets that wrap past the last core, and random backpressure. A behavioural model predicts every output on every cycle for these cases.

// File: rtl/oru_pkg.sv
package oru_pkg;
  typedef struct packed {
    logic pushWin;    // store a notification vector
    logic popWin;     // retire the head window
    logic relOut;     // output handshake completes
    logic acceptReq;  // request header enters its slot
  } oru_strobe_t;
endpackage

// File: rtl/oru_datapath.sv
module oru_datapath
  import oru_pkg::*;
#(
  parameter int NUM_CORES  = 36,
  parameter int HDR_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int WIN_W      = 8,
  localparam int ID_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  oru_strobe_t          strobe,
  input  logic [NUM_CORES-1:0] notifyVec,
  input  logic [ID_W-1:0]      reqSrc,
  input  logic [HDR_W-1:0]     reqHdr,
  output logic                 fifoFull,
  output logic                 fifoEmpty,
  output logic                 remainZero,
  output logic                 expHeld,
  output logic                 slotBusy,
  output logic [ID_W-1:0]      outSrc,
  output logic [HDR_W-1:0]     outHdr,
  output logic [WIN_W-1:0]     outWin
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_CORES - 1);

  logic [NUM_CORES-1:0] winMem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;
  logic [NUM_CORES-1:0] doneMask, headVec, remaining;
  logic [ID_W-1:0]      offset, expCore;
  logic [WIN_W-1:0]     winCnt;
  logic [NUM_CORES-1:0] heldValid;
  logic [HDR_W-1:0]     heldHdr [NUM_CORES];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull   = (count == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty  = (count == '0);
  assign headVec    = fifoEmpty ? '0 : winMem[rdPtr];
  assign remaining  = headVec & ~doneMask;
  assign remainZero = (remaining == '0);

  // rotating search: first set bit at or after offset, wrapping past the last core
  always_comb begin
    logic found;
    int   idx;
    found   = 1'b0;
    expCore = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      idx = int'(offset) + i;
      if (idx >= NUM_CORES) idx = idx - NUM_CORES;
      if (!found && remaining[idx]) begin
        found   = 1'b1;
        expCore = ID_W'(idx);
      end
    end
  end

  assign expHeld  = heldValid[expCore];
  assign slotBusy = (reqSrc > LAST_ID) ? 1'b1 : heldValid[reqSrc];
  assign outSrc   = expCore;
  assign outHdr   = heldHdr[expCore];
  assign outWin   = winCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      doneMask  <= '0;
      offset    <= '0;
      winCnt    <= '0;
      heldValid <= '0;
    end else begin
      if (strobe.pushWin) wrPtr <= nextPtr(wrPtr);
      case ({strobe.pushWin, strobe.popWin})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.popWin) begin
        rdPtr    <= nextPtr(rdPtr);
        doneMask <= '0;
        winCnt   <= winCnt + 1'b1;
        offset   <= (offset == LAST_ID) ? '0 : offset + 1'b1;
      end else if (strobe.relOut) begin
        doneMask[expCore] <= 1'b1;
      end
      if (strobe.relOut)    heldValid[expCore] <= 1'b0;
      if (strobe.acceptReq) heldValid[reqSrc]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushWin)   winMem[wrPtr]   <= notifyVec;
    if (strobe.acceptReq) heldHdr[reqSrc] <= reqHdr;
  end

  a_r7_push_not_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushWin |-> !fifoFull);
  a_r8_accept_free_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptReq |-> (reqSrc <= LAST_ID) && !heldValid[reqSrc]);
  a_r4_release_notified: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relOut |-> headVec[expCore] && !doneMask[expCore] && heldValid[expCore]);
  a_r2_window_steps: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popWin |=> winCnt == WIN_W'($past(winCnt) + 1'b1));
  a_r3_offset_rotates: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popWin |=> offset == (($past(offset) == LAST_ID) ? '0 : ID_W'($past(offset) + 1'b1)));
endmodule

// File: rtl/oru_ctrl.sv
module oru_ctrl
  import oru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        notifyValid,
  input  logic        reqValid,
  input  logic        outReady,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  input  logic        remainZero,
  input  logic        expHeld,
  input  logic        slotBusy,
  output logic        notifyReady,
  output logic        reqReady,
  output logic        outValid,
  output oru_strobe_t strobe
);
  assign notifyReady = !fifoFull;
  assign reqReady    = !slotBusy;
  assign outValid    = !fifoEmpty && !remainZero && expHeld;

  always_comb begin
    strobe.pushWin   = notifyValid && notifyReady;
    strobe.popWin    = !fifoEmpty && remainZero;
    strobe.relOut    = outValid && outReady;
    strobe.acceptReq = reqValid && reqReady;
  end

  // R5: a window retires only once nothing of it is left to release
  a_r5_retire_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popWin |-> !outValid);
endmodule

// File: rtl/order_release_unit.sv
module order_release_unit
  import oru_pkg::*;
#(
  parameter int NUM_CORES  = 36,
  parameter int HDR_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int WIN_W      = 8,
  localparam int ID_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 notifyValid,
  input  logic [NUM_CORES-1:0] notifyVec,
  output logic                 notifyReady,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqSrc,
  input  logic [HDR_W-1:0]     reqHdr,
  output logic                 reqReady,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [ID_W-1:0]      outSrc,
  output logic [HDR_W-1:0]     outHdr,
  output logic [WIN_W-1:0]     outWin
);
  oru_strobe_t strobe;
  logic fifoFull, fifoEmpty, remainZero, expHeld, slotBusy;

  oru_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .reqValid(reqValid),
    .outReady(outReady), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .remainZero(remainZero), .expHeld(expHeld), .slotBusy(slotBusy),
    .notifyReady(notifyReady), .reqReady(reqReady), .outValid(outValid),
    .strobe(strobe)
  );

  oru_datapath #(
    .NUM_CORES(NUM_CORES), .HDR_W(HDR_W), .FIFO_DEPTH(FIFO_DEPTH), .WIN_W(WIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .notifyVec(notifyVec),
    .reqSrc(reqSrc), .reqHdr(reqHdr), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .remainZero(remainZero), .expHeld(expHeld), .slotBusy(slotBusy),
    .outSrc(outSrc), .outHdr(outHdr), .outWin(outWin)
  );

  a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSrc) && $stable(outHdr) && $stable(outWin));
endmodule

// File: tb/order_release_unit_test.sv
module order_release_unit_test;
  localparam int N  = 36;
  localparam int HW = 32;
  localparam int D  = 4;
  localparam int WW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rstN = 1'b0;
  logic notifyValid = 1'b0, reqValid = 1'b0, outReady = 1'b0;
  logic [N-1:0]  notifyVec = '0;
  logic [IW-1:0] reqSrc = '0;
  logic [HW-1:0] reqHdr = '0;
  logic notifyReady, reqReady, outValid;
  logic [IW-1:0] outSrc;
  logic [HW-1:0] outHdr;
  logic [WW-1:0] outWin;

  always #4 clk = ~clk;

  order_release_unit #(.NUM_CORES(N), .HDR_W(HW), .FIFO_DEPTH(D), .WIN_W(WW)) uut (
    .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .notifyVec(notifyVec),
    .notifyReady(notifyReady), .reqValid(reqValid), .reqSrc(reqSrc), .reqHdr(reqHdr),
    .reqReady(reqReady), .outValid(outValid), .outReady(outReady), .outSrc(outSrc),
    .outHdr(outHdr), .outWin(outWin)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit timedOut = 0;
  // behavioural model
  logic [N-1:0]  wq [$];
  int            winNum = 0;
  bit            heldV [N];
  logic [HW-1:0] heldH [N];
  int            relLog [$];
  bit            prevStall = 0;
  logic [IW-1:0] prevSrc;
  logic [HW-1:0] prevHdr;
  // stimulus bookkeeping
  logic [HW-1:0] pendQ [N][$];
  logic [N-1:0]  notifyList [$];
  int            sentWin = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nextCore();
    logic [N-1:0] rem;
    if (wq.size() == 0) return -1;
    rem = wq[0];
    for (int i = 0; i < N; i++) begin
      int c;
      c = (winNum % N + i) % N;
      if (rem[c]) return c;
    end
    return -1;
  endfunction

  task automatic tick(output bit didPush, output bit didAcc);
    int e;
    bit eValid, doRel, doPop;
    logic [N-1:0] tmp;
    #1;
    e = nextCore();
    eValid = (e >= 0) && heldV[e];
    check(notifyReady == (wq.size() < D), "R7 notifyReady", notifyReady, wq.size() < D);
    check(reqReady == !heldV[reqSrc], "R8 reqReady", reqReady, !heldV[reqSrc]);
    check(outValid == eValid, "R4 outValid", outValid, eValid);
    if (eValid && outValid) begin
      check(outSrc == IW'(e), "R3 outSrc", outSrc, e);
      check(outHdr == heldH[e], "R8 outHdr", outHdr, heldH[e]);
      check(outWin == WW'(winNum), "R2 outWin", outWin, WW'(winNum));
    end
    if (prevStall)
      check(outValid && outSrc === prevSrc && outHdr === prevHdr, "R9 stall hold", outSrc, prevSrc);
    prevStall = eValid && !outReady;
    prevSrc = outSrc;
    prevHdr = outHdr;
    doRel   = eValid && outReady;
    doPop   = (wq.size() > 0) && (wq[0] == '0);
    didPush = notifyValid && (wq.size() < D);
    didAcc  = reqValid && !heldV[reqSrc];
    if (doRel) begin
      heldV[e] = 0;
      tmp = wq[0];
      tmp[e] = 1'b0;
      wq[0] = tmp;
      relLog.push_back(e);
    end
    if (doPop) begin
      void'(wq.pop_front());
      winNum++;
    end
    if (didPush) wq.push_back(notifyVec);
    if (didAcc) begin
      heldV[reqSrc] = 1;
      heldH[reqSrc] = reqHdr;
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (cycles > 150000) timedOut = 1;
  endtask

  task automatic idle(input int n);
    bit p, a;
    notifyValid = 0;
    reqValid = 0;
    for (int i = 0; i < n; i++) tick(p, a);
  endtask

  task automatic notifyOne(input logic [N-1:0] v);
    bit p, a;
    notifyVec = v;
    notifyValid = 1;
    reqValid = 0;
    tick(p, a);
    notifyValid = 0;
  endtask

  task automatic sendReq(input int c, input logic [HW-1:0] h);
    bit p, a;
    reqValid = 1;
    reqSrc = IW'(c);
    reqHdr = h;
    tick(p, a);
    reqValid = 0;
  endtask

  function automatic bit anyPending();
    for (int c = 0; c < N; c++) if (pendQ[c].size() > 0 || heldV[c]) return 1;
    return (wq.size() > 0) || (notifyList.size() > 0);
  endfunction

  // random-mode driver: notifications from notifyList, requests from per-core queues
  task automatic driveLoop(input int maxCycles, input bit reqEn, input bit rnd);
    bit p, a;
    int cand [$];
    for (int k = 0; k < maxCycles && !timedOut; k++) begin
      if (!anyPending()) break;
      notifyValid = (notifyList.size() > 0) && (!rnd || ($urandom % 3 != 0));
      notifyVec = (notifyList.size() > 0) ? notifyList[0] : '0;
      cand.delete();
      for (int c = 0; c < N; c++) if (pendQ[c].size() > 0) cand.push_back(c);
      reqValid = reqEn && (cand.size() > 0) && ($urandom % 4 != 0);
      if (cand.size() > 0) begin
        reqSrc = IW'(cand[$urandom % cand.size()]);
        reqHdr = pendQ[reqSrc][0];
      end
      outReady = !rnd || ($urandom % 4 != 0);
      tick(p, a);
      if (p) begin
        for (int c = 0; c < N; c++)
          if (notifyVec[c]) pendQ[c].push_back({WW'(sentWin), 8'(c), 16'($urandom)});
        sentWin++;
        void'(notifyList.pop_front());
      end
      if (a) void'(pendQ[reqSrc].pop_front());
    end
    reqValid = 0;
    notifyValid = 0;
  endtask

  initial begin
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) heldV[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    #1;
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(notifyReady == 1, "R1 notifyReady after reset", notifyReady, 1);
    check(reqReady == 1, "R1 reqReady after reset", reqReady, 1);
    @(negedge clk);

    // window 0: cores 0,3,5, requests arrive lowest rank first (R4)
    outReady = 1;
    notifyOne(N'(1) | (N'(1) << 3) | (N'(1) << 5));
    sendReq(5, 32'h0005_0000);
    sendReq(3, 32'h0003_0000);
    idle(2);
    check(relLog.size() == 0, "R4 early arrivals held", relLog.size(), 0);
    sendReq(0, 32'h0000_0000);
    idle(4);
    check(relLog.size() == 3 && relLog[0] == 0 && relLog[1] == 3 && relLog[2] == 5,
          "R3 window 0 order", relLog.size(), 3);

    // window 1 empty (R6), window 2: cores 1,2,35 so order 2,35,1
    notifyOne('0);
    notifyOne(N'(1 << 1) | N'(1 << 2) | (N'(1) << 35));
    sendReq(1, 32'h0201_0000);
    sendReq(35, 32'h0223_0000);
    sendReq(2, 32'h0202_0000);
    idle(4);
    check(relLog.size() == 6 && relLog[3] == 2 && relLog[4] == 35 && relLog[5] == 1,
          "R6 empty window skipped, R3 order in window 2", relLog.size(), 6);
    sentWin = 3;

    // R7: fill the window queue with no requests
    for (int i = 0; i < 6; i++) notifyList.push_back(N'(1) << 7);
    driveLoop(10, 0, 0);
    check(notifyReady == 0, "R7 queue full", notifyReady, 0);
    check(notifyList.size() == 2, "R7 windows accepted", notifyList.size(), 2);
    driveLoop(200, 1, 0);

    // R5: random windows, random arrival and backpressure, offsets wrap past core 35
    for (int w = 0; w < 90; w++) begin
      v = '0;
      if (w % 17 == 5) v = '1;
      else if (w % 11 != 3)
        for (int c = 0; c < N; c++) if ($urandom % 6 == 0) v[c] = 1'b1;
      notifyList.push_back(v);
    end
    driveLoop(100000, 1, 1);
    idle(3);
    check(!anyPending(), "R5 all windows drained", anyPending(), 0);
    check(winNum == sentWin, "R2 window count", winNum, sentWin);

    if (timedOut) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule